// File: doc/BRIEF.md
# GPIO Edge Interrupt Detector with Bank Aggregation

This block watches a vector of already-synchronized GPIO pin levels and turns selected level changes into interrupts. For every pin there is a separate enable for a low-to-high transition and for a high-to-low transition. Any transition of an enabled kind sets a sticky status bit, which software later clears by writing a one to it. The block does not look at pin direction, so pins that are driven as outputs are checked the same way as inputs.

Status bits are grouped sixteen at a time. Each group of sixteen drives one bank interrupt line, and a per-bank enable register gates that line. The first few pins also have their own interrupt lines, one per pin, for a system that routes those pins straight to its interrupt controller. Those lines are gated by the enable bit of bank 0.

All registers sit on a simple 32-bit write bus with a combinational read port. Trigger enables cannot be read back; they are changed only through separate set and clear strobe registers.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all trigger enables, status bits and bank enables are 0. Every interrupt output is low, and pin transitions record nothing until a trigger is enabled.
- R2: Writing a word to a set-rising register (group offset 0x14) or a set-falling register (0x1C) enables that trigger for each pin whose bit is 1. Bits written as 0 leave their enables unchanged.
- R3: Writing a word to a clear-rising register (0x18) or a clear-falling register (0x20) disables that trigger for each pin whose bit is 1. After that, transitions of that kind on the pin record nothing.
- R4: A rising transition is a pin sampled 1 at a clock edge after being sampled 0 at the previous edge; a falling transition is the reverse. An enabled transition sets the pin's status bit at the same clock edge that first samples the new level.
- R5: When a pin has both triggers enabled, a transition in either direction sets its status bit.
- R6: Writing to the status register (group offset 0x24) clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R7: If a new enabled transition and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Bank line b is high exactly when bank enable bit b is 1 and at least one of status bits 16b to 16b+15 is 1. Within pin group g, bits 0 to 15 feed bank 2g and bits 16 to 31 feed bank 2g+1.
- R9: The bank enable register at address 0x08 holds one bit per bank in bits [NUM_BANKS-1:0]. It is written whole and reads back its value, and the bits above NUM_BANKS read as 0.
- R10: Direct line i (i < NUM_DIRECT) is high exactly when status bit i is 1 and bank enable bit 0 is 1.
- R11: Pin group g occupies the addresses starting at 0x10 + 0x28*g. The status register of each group and the bank enable register read back their contents; every other address reads as 0.
- R12: A status bit stays set after its pin returns to its former level, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Synchronized pin levels (inputs or looped-back outputs) |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| bank_irq_o | output | NUM_BANKS | One interrupt line per 16-pin bank |
| direct_irq_o | output | NUM_DIRECT | One interrupt line per pin for the first pins |

## Verification
The bench uses the default build: 64 pins, which gives two register groups and four banks, and eight direct lines. With two groups, the bench can show that each group is decoded separately and that the four banks map correctly across the group boundary at bit 16 and at the second group. With eight direct lines, it can show that the direct lines share the bank 0 enable with the first bank line. Directed cases cover a transition that coincides with a clear of the same bit, and bank enable bits written above the bank count. A seeded random stream of pin toggles and register writes is then compared cycle by cycle against a reference model in the bench.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

    // Pins per register group and per interrupt bank
    localparam int unsigned GRP_BITS  = 32;
    localparam int unsigned BANK_PINS = 16;

    // Address layout (byte addresses)
    localparam int unsigned BANK_EN_ADDR  = 32'h08;
    localparam int unsigned GRP_BASE      = 32'h10;
    localparam int unsigned GRP_STRIDE    = 32'h28;
    localparam int unsigned OFS_SET_RISE  = 32'h14;
    localparam int unsigned OFS_CLR_RISE  = 32'h18;
    localparam int unsigned OFS_SET_FALL  = 32'h1C;
    localparam int unsigned OFS_CLR_FALL  = 32'h20;
    localparam int unsigned OFS_STATUS    = 32'h24;

    // Per-group write strobes produced by the decoder
    typedef struct packed {
        logic set_rise;
        logic clr_rise;
        logic set_fall;
        logic clr_fall;
        logic clr_status;
    } grp_wr_t;

endpackage

// File: rtl/gpio_eirq_decode.sv
module gpio_eirq_decode
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_GROUPS = 2
) (
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    output grp_wr_t [NUM_GROUPS-1:0]          grp_wr_o,
    output logic    [NUM_GROUPS-1:0]          grp_rd_sel_o,
    output logic                              ben_wr_o,
    output logic                              ben_rd_sel_o
);

    always_comb begin
        ben_rd_sel_o = (addr_i == ADDR_W'(BANK_EN_ADDR));
        ben_wr_o     = wr_i && ben_rd_sel_o;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            grp_rd_sel_o[g]        = (addr_i == ADDR_W'(GRP_BASE + g * GRP_STRIDE + OFS_STATUS));
            grp_wr_o[g].set_rise   = wr_i && (addr_i == ADDR_W'(GRP_BASE + g * GRP_STRIDE + OFS_SET_RISE));
            grp_wr_o[g].clr_rise   = wr_i && (addr_i == ADDR_W'(GRP_BASE + g * GRP_STRIDE + OFS_CLR_RISE));
            grp_wr_o[g].set_fall   = wr_i && (addr_i == ADDR_W'(GRP_BASE + g * GRP_STRIDE + OFS_SET_FALL));
            grp_wr_o[g].clr_fall   = wr_i && (addr_i == ADDR_W'(GRP_BASE + g * GRP_STRIDE + OFS_CLR_FALL));
            grp_wr_o[g].clr_status = wr_i && grp_rd_sel_o[g];
        end
    end

endmodule

// File: rtl/gpio_eirq_group.sv
module gpio_eirq_group
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  grp_wr_t          strb_i,
    output logic [WIDTH-1:0] status_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] rise_en;
        logic [WIDTH-1:0] fall_en;
        logic [WIDTH-1:0] status;
    } grp_state_t;

    grp_state_t       st_d, st_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] clr_mask;

    always_comb begin
        hit      = (pins_i & ~st_q.prev & st_q.rise_en)
                 | (~pins_i & st_q.prev & st_q.fall_en);
        clr_mask = strb_i.clr_status ? wdata_i : '0;
        st_d      = st_q;
        st_d.prev = pins_i;
        if (strb_i.set_rise) st_d.rise_en = st_q.rise_en | wdata_i;
        if (strb_i.clr_rise) st_d.rise_en = st_q.rise_en & ~wdata_i;
        if (strb_i.set_fall) st_d.fall_en = st_q.fall_en | wdata_i;
        if (strb_i.clr_fall) st_d.fall_en = st_q.fall_en & ~wdata_i;
        // new edges win over a same-cycle clear
        st_d.status = (st_q.status & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R6
    status_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.status) & ~st_q.status & ~$past(clr_mask)) == '0);

    // R4
    status_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status & ~$past(st_q.status) & ~$past(hit)) == '0);

    // R7
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) & ~st_q.status) == '0);

    // R3
    rise_clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.clr_rise |=> (st_q.rise_en & $past(wdata_i)) == '0);

    // R3
    fall_clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.clr_fall |=> (st_q.fall_en & $past(wdata_i)) == '0);

endmodule

// File: rtl/gpio_eirq_bankgate.sv
module gpio_eirq_bankgate
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 64,
    parameter int unsigned NUM_DIRECT = 8,
    localparam int unsigned NUM_BANKS = NUM_PINS / BANK_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ben_wr_i,
    input  logic [NUM_BANKS-1:0]  ben_wdata_i,
    input  logic [NUM_PINS-1:0]   status_i,
    output logic [NUM_BANKS-1:0]  ben_o,
    output logic [NUM_BANKS-1:0]  bank_irq_o,
    output logic [NUM_DIRECT-1:0] direct_irq_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0] ben;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ben_wr_i) st_d.ben = ben_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ben_o = st_q.ben;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_irq_o[b] = st_q.ben[b] & (|status_i[b*BANK_PINS +: BANK_PINS]);

        // R8
        quiet_bank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_i[b*BANK_PINS +: BANK_PINS] == '0) |-> !bank_irq_o[b]);
    end

    for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
        assign direct_irq_o[i] = st_q.ben[0] & status_i[i];
    end

    // R9
    ben_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ben_wr_i |=> st_q.ben == $past(ben_wdata_i));

    // R10
    direct_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_irq_o & ~status_i[NUM_DIRECT-1:0]) == '0);

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 64,
    parameter int unsigned NUM_DIRECT = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    localparam int unsigned NUM_GROUPS = NUM_PINS / GRP_BITS,
    localparam int unsigned NUM_BANKS  = NUM_PINS / BANK_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  bus_wr_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic [NUM_BANKS-1:0]  bank_irq_o,
    output logic [NUM_DIRECT-1:0] direct_irq_o
);

    grp_wr_t [NUM_GROUPS-1:0] grp_wr;
    logic    [NUM_GROUPS-1:0] grp_rd_sel;
    logic                     ben_wr;
    logic                     ben_rd_sel;
    logic    [NUM_PINS-1:0]   status;
    logic    [NUM_BANKS-1:0]  ben;

    gpio_eirq_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_decode (
        .wr_i         (bus_wr_i),
        .addr_i       (bus_addr_i),
        .grp_wr_o     (grp_wr),
        .grp_rd_sel_o (grp_rd_sel),
        .ben_wr_o     (ben_wr),
        .ben_rd_sel_o (ben_rd_sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gpio_eirq_group #(
            .WIDTH (GRP_BITS)
        ) u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins_i   (pins_i[g*GRP_BITS +: GRP_BITS]),
            .wdata_i  (bus_wdata_i[GRP_BITS-1:0]),
            .strb_i   (grp_wr[g]),
            .status_o (status[g*GRP_BITS +: GRP_BITS])
        );
    end

    gpio_eirq_bankgate #(
        .NUM_PINS   (NUM_PINS),
        .NUM_DIRECT (NUM_DIRECT)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .ben_wr_i     (ben_wr),
        .ben_wdata_i  (bus_wdata_i[NUM_BANKS-1:0]),
        .status_i     (status),
        .ben_o        (ben),
        .bank_irq_o   (bank_irq_o),
        .direct_irq_o (direct_irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (ben_rd_sel) bus_rdata_o[NUM_BANKS-1:0] = ben;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_rd_sel[g]) bus_rdata_o[GRP_BITS-1:0] = status[g*GRP_BITS +: GRP_BITS];
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_irq_o == '0 && direct_irq_o == '0));

endmodule

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NB = 4;
    localparam int ND = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NP-1:0] pins = '0;
    logic          bus_wr = 0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] bank_irq;
    logic [ND-1:0] direct_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [NP-1:0] m_rise, m_fall, m_stat, m_prev;
    logic [NB-1:0] m_ben;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bank_irq_o   (bank_irq),
        .direct_irq_o (direct_irq)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [7:0] a);
        if (a == 8'h08) return {28'b0, m_ben};
        for (int g = 0; g < 2; g++)
            if (a == 8'(16 + 40*g + 36)) return m_stat[32*g +: 32];
        return 32'h0;
    endfunction

    function automatic logic [NB-1:0] mbank();
        logic [NB-1:0] r;
        for (int b = 0; b < NB; b++) r[b] = m_ben[b] & (|m_stat[16*b +: 16]);
        return r;
    endfunction

    // one clock: drive, update model at the edge, compare at negedge
    task automatic cyc(logic [NP-1:0] p, logic w, logic [7:0] a, logic [31:0] d);
        logic [NP-1:0] hit, clr;
        pins = p; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        hit = (p & ~m_prev & m_rise) | (~p & m_prev & m_fall);
        clr = '0;
        for (int g = 0; g < 2; g++) begin
            int base = 16 + 40*g;
            if (w && a == 8'(base + 36)) clr[32*g +: 32] = d;
            if (w && a == 8'(base + 20)) m_rise[32*g +: 32] |= d;
            if (w && a == 8'(base + 24)) m_rise[32*g +: 32] &= ~d;
            if (w && a == 8'(base + 28)) m_fall[32*g +: 32] |= d;
            if (w && a == 8'(base + 32)) m_fall[32*g +: 32] &= ~d;
        end
        if (w && a == 8'h08) m_ben = d[NB-1:0];
        m_stat = (m_stat & ~clr) | hit;
        m_prev = p;
        @(negedge clk);
        bus_wr = 0;
        chk("R8 bank lines", 64'(bank_irq), 64'(mbank()));
        chk("R10 direct lines", 64'(direct_irq), 64'(m_stat[ND-1:0] & {ND{m_ben[0]}}));
        chk("R11 read data", 64'(bus_rdata), 64'(mread(a)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] p;
        logic [7:0] addrs [11];
        void'($urandom(32'd20240611));
        m_rise = '0; m_fall = '0; m_stat = '0; m_prev = '0; m_ben = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 bank lines", 64'(bank_irq), 0);
        chk("R1 direct lines", 64'(direct_irq), 0);
        chk("R1 status0", 64'(bus_rdata), 0);
        cyc('0, 1, 8'h08, 32'hF);
        chk("R9 bank enable read", 64'(bus_rdata), 64'hF);
        cyc(64'h8, 0, 8'h34, 0);
        chk("R1 no trigger no status", 64'(bus_rdata), 0);

        // R2 / R4: rising on pin 3
        cyc(64'h0, 1, 8'h24, 32'h8);
        cyc(64'h0, 0, 8'h34, 0);
        cyc(64'h8, 0, 8'h34, 0);
        chk("R4 rising captured", 64'(bus_rdata), 64'h8);
        chk("R8 bank0 up", 64'(bank_irq), 64'h1);
        chk("R10 direct3 up", 64'(direct_irq), 64'h8);
        // R12: returns low, bit sticks (falling not enabled)
        cyc(64'h0, 0, 8'h34, 0);
        chk("R12 sticky", 64'(bus_rdata), 64'h8);
        // R6: zero write no effect, then clear
        cyc(64'h0, 1, 8'h34, 32'h0);
        chk("R6 zero write keeps", 64'(bus_rdata), 64'h8);
        cyc(64'h0, 1, 8'h34, 32'h8);
        chk("R6 one write clears", 64'(bus_rdata), 64'h0);
        // R3: clear rising, no capture
        cyc(64'h0, 1, 8'h28, 32'h8);
        cyc(64'h8, 0, 8'h34, 0);
        chk("R3 disabled rising", 64'(bus_rdata), 64'h0);

        // R5: both edges on pin 20 -> bank 1
        cyc(64'h0, 1, 8'h24, 32'h0010_0000);
        cyc(64'h0, 1, 8'h2C, 32'h0010_0000);
        cyc(64'h0010_0000, 0, 8'h34, 0);
        chk("R5 rise seen", 64'(bus_rdata), 64'h0010_0000);
        chk("R8 bank1 from bit20", 64'(bank_irq), 64'h2);
        cyc(64'h0010_0000, 1, 8'h34, 32'h0010_0000);
        cyc(64'h0, 0, 8'h34, 0);
        chk("R5 fall seen", 64'(bus_rdata), 64'h0010_0000);
        cyc(64'h0, 1, 8'h34, 32'hFFFF_FFFF);

        // R7: edge and clear in the same cycle on pin 5
        cyc(64'h0, 1, 8'h24, 32'h20);
        cyc(64'h20, 1, 8'h34, 32'h20);
        chk("R7 edge beats clear", 64'(bus_rdata), 64'h20);
        cyc(64'h20, 1, 8'h34, 32'h20);

        // R8 / R9: group 1 pin 40 -> bank 2, gated
        cyc(64'h20, 1, 8'h08, 32'hB);
        cyc(64'h20, 1, 8'h4C, 32'h100);
        cyc(64'h100_0000_0020, 0, 8'h5C, 0);
        chk("R11 group1 status", 64'(bus_rdata), 64'h100);
        chk("R8 bank2 gated off", 64'(bank_irq), 64'h0);
        cyc(64'h100_0000_0020, 1, 8'h08, 32'hFFFF_FFFF);
        chk("R9 upper bits zero", 64'(bus_rdata), 64'hF);
        chk("R8 bank2 enabled", 64'(bank_irq), 64'h4);
        cyc(64'h100_0000_0020, 0, 8'h00, 0);
        chk("R11 unmapped reads zero", 64'(bus_rdata), 64'h0);

        // random stream
        addrs = '{8'h08, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34,
                  8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C};
        p = pins;
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] flip;
            flip = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            p = p ^ flip;
            cyc(p, ($urandom % 2) == 0, addrs[$urandom % 11],
                (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule